// File: doc/BRIEF.md
# Area CCD Readout Clock Sequencer

This block produces the logic-level clock pattern that drives a two-phase area CCD through one exposure. On a start pulse it opens the shutter for a programmable number of system clocks. It then closes the shutter and walks the image down one row at a time with the two vertical phases. After each row shift it clocks the horizontal register out pixel by pixel. A summing gate and a transfer gate follow their phases. A reset gate pulses once per pixel, and a pixel-valid strobe tells an external converter when to sample. Level shifters, clock drivers and the converter sit outside the block.

Every duration is counted in system clocks: the vertical pulse width, the gate-to-horizontal overlap, the horizontal half period and the reset width. Each one is a parameter. A declared clock rate lets elaboration reject any value below the sensor's limits: a 6 µs vertical pulse, a 3 µs overlap, a 500 ns horizontal half (so at most 1 MHz per pixel) and a 100 ns reset pulse. The reset pulse must also be shorter than the horizontal half. Each readout line has four groups of dummy pixels around the signal pixels. Each frame has flushed rows before and after the active rows. All of these counts are parameters too. The defaults describe a 512 × 512 sensor with 532-pixel lines and 520 row transfers.

Top module: `ccd_clk_seq`

## Requirements
- R1: After reset every output is low.
- R2: A start pulse is accepted only while the sequencer is idle. A start during integration or readout changes neither the timing of the running frame nor the state after it, and no second frame follows.
- R3: shutterOpen rises one clock after the edge that samples start. It stays high for intLen clocks, or for one clock when intLen is 0. It is low whenever any vertical clock or the first horizontal clock is high.
- R4: Each frame makes LEAD_ROWS+ACT_ROWS+TRAIL_ROWS row transfers. Each transfer is a vClk1 pulse followed by a vClk2 pulse, and each pulse is high for exactly VPULSE clocks.
- R5: xferGate always equals vClk2, and sumGate always equals hClk2.
- R6: hClk1 is high when xferGate falls, and hClk2 first rises exactly OVLP_CYC clocks after that fall.
- R7: Each line is a run of pixel periods of 2·HHALF clocks. The first half of each period has hClk2 high and hClk1 low, and the second half is the reverse. The two never overlap.
- R8: rstGate pulses once per pixel for RSTW clocks, at the start of the half where hClk2 is high.
- R9: pixValid is high for one clock, the last clock of a pixel period. This happens only for 0-based column indices DUM_A+DUM_B through DUM_A+DUM_B+SIG_PIX-1, and only in 0-based row transfers LEAD_ROWS through LEAD_ROWS+ACT_ROWS-1.
- R10: lineStart is high with pixValid of the first signal column of every active row. frameEnd is high with pixValid of the last signal column of the last active row.
- R11: One clock after the last line ends, every output is low again and a new start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Single-clock request to begin a frame |
| intLen | input | INT_W | Integration length in clocks, sampled at start |
| vClk1 | output | 1 | Vertical phase 1 |
| vClk2 | output | 1 | Vertical phase 2 |
| xferGate | output | 1 | Transfer gate, follows vertical phase 2 |
| hClk1 | output | 1 | Horizontal phase 1 |
| hClk2 | output | 1 | Horizontal phase 2 |
| sumGate | output | 1 | Summing gate, follows horizontal phase 2 |
| rstGate | output | 1 | Output node reset pulse |
| shutterOpen | output | 1 | Shutter open request |
| pixValid | output | 1 | Sample strobe for the converter |
| lineStart | output | 1 | First signal pixel of an active row |
| frameEnd | output | 1 | Last signal pixel of the frame |

## Verification
Two things can fall in the same cycle: a start request and a sequencer that is already busy. The bench sends a second start in the middle of integration and another in the middle of readout. It judges the result by comparing every pixel-valid edge against a precomputed schedule and by confirming that no extra row transfer appears after the frame. Markers and strobes also coincide: lineStart and frameEnd must appear in exactly the cycle of their own pixel-valid. Each scoreboard item carries both flags, so a marker one clock early or late is caught.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INTEG,
    ST_VUP1,
    ST_VUP2,
    ST_OVLP,
    ST_HSHIFT
  } seqState_t;

  typedef enum logic [1:0] {
    LD_INT,
    LD_VERT,
    LD_OVLP
  } tmrSel_t;

  // strobes and levels from control to datapath
  typedef struct packed {
    logic    tmrLoad;
    tmrSel_t tmrSel;
    logic    rowClr;
    logic    rowInc;
    logic    pixRun;
    logic    shutLvl;
    logic    v1Lvl;
    logic    v2Lvl;
    logic    hHold;
  } seqStrobe_t;

  typedef struct packed {
    logic v1;
    logic v2;
    logic tg;
    logic h1;
    logic h2;
    logic sg;
    logic rg;
    logic shut;
    logic valid;
    logic lstart;
    logic fend;
  } pinBus_t;

  // smallest clock count covering ns at mhz
  function automatic int minCycles(input int ns, input int mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

  function automatic int maxInt(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ccd_seq_ctrl.sv
module ccd_seq_ctrl
  import ccd_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       tmrDone,
  input  logic       lineDone,
  input  logic       lastRow,
  output seqStrobe_t strb
);

  seqState_t state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    strb     = '0;
    strb.tmrSel = LD_INT;
    case (state)
      ST_IDLE: begin
        if (startReq) begin
          stateNxt     = ST_INTEG;
          strb.tmrLoad = 1'b1;
          strb.tmrSel  = LD_INT;
          strb.rowClr  = 1'b1;
        end
      end
      ST_INTEG: begin
        strb.shutLvl = 1'b1;
        if (tmrDone) begin
          stateNxt     = ST_VUP1;
          strb.tmrLoad = 1'b1;
          strb.tmrSel  = LD_VERT;
        end
      end
      ST_VUP1: begin
        strb.v1Lvl = 1'b1;
        strb.hHold = 1'b1;
        if (tmrDone) begin
          stateNxt     = ST_VUP2;
          strb.tmrLoad = 1'b1;
          strb.tmrSel  = LD_VERT;
        end
      end
      ST_VUP2: begin
        strb.v2Lvl = 1'b1;
        strb.hHold = 1'b1;
        if (tmrDone) begin
          stateNxt     = ST_OVLP;
          strb.tmrLoad = 1'b1;
          strb.tmrSel  = LD_OVLP;
        end
      end
      ST_OVLP: begin
        strb.hHold = 1'b1;
        if (tmrDone) stateNxt = ST_HSHIFT;
      end
      ST_HSHIFT: begin
        strb.pixRun = 1'b1;
        if (lineDone) begin
          strb.rowInc = 1'b1;
          if (lastRow) begin
            stateNxt = ST_IDLE;
          end else begin
            stateNxt     = ST_VUP1;
            strb.tmrLoad = 1'b1;
            strb.tmrSel  = LD_VERT;
          end
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/ccd_seq_dpath.sv
module ccd_seq_dpath
  import ccd_seq_pkg::*;
#(
  parameter int INT_W      = 24,
  parameter int VPULSE     = 750,
  parameter int OVLP_CYC   = 375,
  parameter int HHALF      = 63,
  parameter int RSTW       = 13,
  parameter int DUM_A      = 4,
  parameter int DUM_B      = 8,
  parameter int SIG_PIX    = 512,
  parameter int DUM_C      = 5,
  parameter int DUM_D      = 3,
  parameter int LEAD_ROWS  = 4,
  parameter int ACT_ROWS   = 512,
  parameter int TRAIL_ROWS = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [INT_W-1:0] intLen,
  input  seqStrobe_t       strb,
  output logic             tmrDone,
  output logic             lineDone,
  output logic             lastRow,
  output pinBus_t          pins
);

  localparam int LINE_PIX   = DUM_A + DUM_B + SIG_PIX + DUM_C + DUM_D;
  localparam int PIX_CYC    = 2 * HHALF;
  localparam int TOTAL_ROWS = LEAD_ROWS + ACT_ROWS + TRAIL_ROWS;
  localparam int SIG_FIRST  = DUM_A + DUM_B;
  localparam int SIG_LAST   = SIG_FIRST + SIG_PIX - 1;
  localparam int ACT_FIRST  = LEAD_ROWS;
  localparam int ACT_LAST   = LEAD_ROWS + ACT_ROWS - 1;
  localparam int TMR_W      = maxInt(INT_W, $clog2(maxInt(VPULSE, OVLP_CYC) + 1));
  localparam int SUB_W      = $clog2(PIX_CYC + 1);
  localparam int PIX_W      = $clog2(LINE_PIX + 1);
  localparam int ROW_W      = $clog2(TOTAL_ROWS + 1);

  localparam logic [SUB_W-1:0] SUB_LAST_C  = SUB_W'(PIX_CYC - 1);
  localparam logic [SUB_W-1:0] HHALF_C     = SUB_W'(HHALF);
  localparam logic [SUB_W-1:0] RSTW_C      = SUB_W'(RSTW);
  localparam logic [PIX_W-1:0] PIX_LAST_C  = PIX_W'(LINE_PIX - 1);
  localparam logic [PIX_W-1:0] SIG_FIRST_C = PIX_W'(SIG_FIRST);
  localparam logic [PIX_W-1:0] SIG_LAST_C  = PIX_W'(SIG_LAST);
  localparam logic [ROW_W-1:0] ACT_FIRST_C = ROW_W'(ACT_FIRST);
  localparam logic [ROW_W-1:0] ACT_LAST_C  = ROW_W'(ACT_LAST);
  localparam logic [ROW_W-1:0] ROW_LAST_C  = ROW_W'(TOTAL_ROWS - 1);

  logic [TMR_W-1:0] tmr, tmrLdVal;
  logic [SUB_W-1:0] subCnt;
  logic [PIX_W-1:0] pixIdx;
  logic [ROW_W-1:0] rowIdx;
  logic             halfA, endPix, sigCol, actRow;
  pinBus_t          pinNxt;

  // phase timer: loaded with N-1, state lasts N clocks
  always_comb begin
    case (strb.tmrSel)
      LD_INT:  tmrLdVal = (intLen == '0) ? '0 : (TMR_W'(intLen) - TMR_W'(1));
      LD_VERT: tmrLdVal = TMR_W'(VPULSE - 1);
      LD_OVLP: tmrLdVal = TMR_W'(OVLP_CYC - 1);
      default: tmrLdVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             tmr <= '0;
    else if (strb.tmrLoad) tmr <= tmrLdVal;
    else if (tmr != '0)    tmr <= tmr - TMR_W'(1);
  end

  assign tmrDone = (tmr == '0);

  // pixel position within the line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      subCnt <= '0;
      pixIdx <= '0;
    end else if (strb.pixRun) begin
      if (subCnt == SUB_LAST_C) begin
        subCnt <= '0;
        pixIdx <= (pixIdx == PIX_LAST_C) ? '0 : pixIdx + PIX_W'(1);
      end else begin
        subCnt <= subCnt + SUB_W'(1);
      end
    end
  end

  // row transfer index within the frame
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rowIdx <= '0;
    else if (strb.rowClr) rowIdx <= '0;
    else if (strb.rowInc) rowIdx <= rowIdx + ROW_W'(1);
  end

  assign endPix   = (subCnt == SUB_LAST_C);
  assign lineDone = strb.pixRun && endPix && (pixIdx == PIX_LAST_C);
  assign lastRow  = (rowIdx == ROW_LAST_C);
  assign halfA    = (subCnt < HHALF_C);
  assign sigCol   = (pixIdx >= SIG_FIRST_C) && (pixIdx <= SIG_LAST_C);
  assign actRow   = (rowIdx >= ACT_FIRST_C) && (rowIdx <= ACT_LAST_C);

  always_comb begin
    pinNxt        = '0;
    pinNxt.shut   = strb.shutLvl;
    pinNxt.v1     = strb.v1Lvl;
    pinNxt.v2     = strb.v2Lvl;
    pinNxt.tg     = strb.v2Lvl;
    pinNxt.h1     = strb.hHold | (strb.pixRun & ~halfA);
    pinNxt.h2     = strb.pixRun & halfA;
    pinNxt.sg     = strb.pixRun & halfA;
    pinNxt.rg     = strb.pixRun & (subCnt < RSTW_C);
    pinNxt.valid  = strb.pixRun & endPix & sigCol & actRow;
    pinNxt.lstart = pinNxt.valid & (pixIdx == SIG_FIRST_C);
    pinNxt.fend   = pinNxt.valid & (pixIdx == SIG_LAST_C) & (rowIdx == ACT_LAST_C);
  end

  // glitch-free registered pin drive
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pins <= '0;
    else       pins <= pinNxt;
  end

endmodule

// File: rtl/ccd_clk_seq.sv
module ccd_clk_seq
  import ccd_seq_pkg::*;
#(
  parameter int CLK_MHZ    = 125,
  parameter int INT_W      = 24,
  parameter int VPULSE     = 750,
  parameter int OVLP_CYC   = 375,
  parameter int HHALF      = 63,
  parameter int RSTW       = 13,
  parameter int DUM_A      = 4,
  parameter int DUM_B      = 8,
  parameter int SIG_PIX    = 512,
  parameter int DUM_C      = 5,
  parameter int DUM_D      = 3,
  parameter int LEAD_ROWS  = 4,
  parameter int ACT_ROWS   = 512,
  parameter int TRAIL_ROWS = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [INT_W-1:0] intLen,
  output logic             vClk1,
  output logic             vClk2,
  output logic             xferGate,
  output logic             hClk1,
  output logic             hClk2,
  output logic             sumGate,
  output logic             rstGate,
  output logic             shutterOpen,
  output logic             pixValid,
  output logic             lineStart,
  output logic             frameEnd
);

  localparam int MIN_V   = minCycles(6000, CLK_MHZ);
  localparam int MIN_OVL = minCycles(3000, CLK_MHZ);
  localparam int MIN_H   = minCycles(500, CLK_MHZ);
  localparam int MIN_PIX = minCycles(1000, CLK_MHZ);
  localparam int MIN_R   = minCycles(100, CLK_MHZ);

  // elaboration-time limit checks
  if (VPULSE < MIN_V) begin : g_badVert
    $error("vertical pulse below 6 us");
  end
  if (OVLP_CYC < MIN_OVL) begin : g_badOvlp
    $error("gate overlap below 3 us");
  end
  if (HHALF < MIN_H || 2 * HHALF < MIN_PIX) begin : g_badHoriz
    $error("horizontal half below 500 ns");
  end
  if (RSTW < MIN_R || RSTW >= HHALF) begin : g_badReset
    $error("reset pulse too short or not inside the half period");
  end
  if (SIG_PIX < 1 || ACT_ROWS < 1) begin : g_badGeom
    $error("line or frame has no signal area");
  end

  seqStrobe_t strb;
  pinBus_t    pins;
  logic       tmrDone, lineDone, lastRow;

  ccd_seq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .tmrDone  (tmrDone),
    .lineDone (lineDone),
    .lastRow  (lastRow),
    .strb     (strb)
  );

  ccd_seq_dpath #(
    .INT_W      (INT_W),
    .VPULSE     (VPULSE),
    .OVLP_CYC   (OVLP_CYC),
    .HHALF      (HHALF),
    .RSTW       (RSTW),
    .DUM_A      (DUM_A),
    .DUM_B      (DUM_B),
    .SIG_PIX    (SIG_PIX),
    .DUM_C      (DUM_C),
    .DUM_D      (DUM_D),
    .LEAD_ROWS  (LEAD_ROWS),
    .ACT_ROWS   (ACT_ROWS),
    .TRAIL_ROWS (TRAIL_ROWS)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .intLen   (intLen),
    .strb     (strb),
    .tmrDone  (tmrDone),
    .lineDone (lineDone),
    .lastRow  (lastRow),
    .pins     (pins)
  );

  assign vClk1       = pins.v1;
  assign vClk2       = pins.v2;
  assign xferGate    = pins.tg;
  assign hClk1       = pins.h1;
  assign hClk2       = pins.h2;
  assign sumGate     = pins.sg;
  assign rstGate     = pins.rg;
  assign shutterOpen = pins.shut;
  assign pixValid    = pins.valid;
  assign lineStart   = pins.lstart;
  assign frameEnd    = pins.fend;

endmodule

// File: rtl/ccd_clk_seq_chk.sv
module ccd_clk_seq_chk #(
  parameter int VPULSE   = 750,
  parameter int OVLP_CYC = 375
) (
  input logic clk,
  input logic rstN,
  input logic vClk1,
  input logic vClk2,
  input logic xferGate,
  input logic hClk1,
  input logic hClk2,
  input logic rstGate,
  input logic shutterOpen,
  input logic pixValid,
  input logic lineStart,
  input logic frameEnd
);

  int   v1Run;
  int   ovlCnt;
  logic tgPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      v1Run  <= 0;
      ovlCnt <= 0;
      tgPrev <= 1'b0;
    end else begin
      tgPrev <= xferGate;
      v1Run  <= vClk1 ? v1Run + 1 : 0;
      if (tgPrev && !xferGate)       ovlCnt <= 1;
      else if (ovlCnt != 0 && !hClk2) ovlCnt <= ovlCnt + 1;
      else                            ovlCnt <= 0;
    end
  end

  assert_shutter_closed_R3: assert property (@(posedge clk) disable iff (!rstN)
    shutterOpen |-> !vClk1 && !vClk2 && !hClk1);

  assert_vpulse_width_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!vClk1 && v1Run != 0) |-> v1Run == VPULSE);

  assert_overlap_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (tgPrev && !xferGate) |-> hClk1);

  assert_overlap_len_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ovlCnt != 0 && hClk2) |-> ovlCnt == OVLP_CYC);

  assert_h_compl_R7: assert property (@(posedge clk) disable iff (!rstN)
    hClk2 |-> !hClk1);

  assert_rg_in_half_R8: assert property (@(posedge clk) disable iff (!rstN)
    rstGate |-> hClk2);

  assert_valid_after_rg_R9: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |-> hClk1 && !rstGate);

  assert_line_mark_R10: assert property (@(posedge clk) disable iff (!rstN)
    lineStart |-> pixValid);

  assert_frame_mark_R10: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |-> pixValid);

endmodule

bind ccd_clk_seq ccd_clk_seq_chk #(
  .VPULSE   (VPULSE),
  .OVLP_CYC (OVLP_CYC)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .vClk1       (vClk1),
  .vClk2       (vClk2),
  .xferGate    (xferGate),
  .hClk1       (hClk1),
  .hClk2       (hClk2),
  .rstGate     (rstGate),
  .shutterOpen (shutterOpen),
  .pixValid    (pixValid),
  .lineStart   (lineStart),
  .frameEnd    (frameEnd)
);

// File: tb/ccd_clk_seq_tb_top.sv
module ccd_clk_seq_tb_top;

  localparam int CLK_MHZ  = 2;
  localparam int INT_W    = 8;
  localparam int VPULSE   = 12;
  localparam int OVLP_CYC = 6;
  localparam int HHALF    = 3;
  localparam int RSTW     = 1;
  localparam int DUM_A = 1, DUM_B = 1, SIG_PIX = 4, DUM_C = 1, DUM_D = 1;
  localparam int LEAD_ROWS = 1, ACT_ROWS = 2, TRAIL_ROWS = 1;
  localparam int LINE_PIX   = DUM_A + DUM_B + SIG_PIX + DUM_C + DUM_D;
  localparam int PIX_CYC    = 2 * HHALF;
  localparam int TOTAL_ROWS = LEAD_ROWS + ACT_ROWS + TRAIL_ROWS;
  localparam int ROWCYC     = 2 * VPULSE + OVLP_CYC + LINE_PIX * PIX_CYC;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [INT_W-1:0] intLen = '0;
  logic vClk1, vClk2, xferGate, hClk1, hClk2, sumGate, rstGate;
  logic shutterOpen, pixValid, lineStart, frameEnd;

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  ccd_clk_seq #(
    .CLK_MHZ(CLK_MHZ), .INT_W(INT_W), .VPULSE(VPULSE), .OVLP_CYC(OVLP_CYC),
    .HHALF(HHALF), .RSTW(RSTW), .DUM_A(DUM_A), .DUM_B(DUM_B), .SIG_PIX(SIG_PIX),
    .DUM_C(DUM_C), .DUM_D(DUM_D), .LEAD_ROWS(LEAD_ROWS), .ACT_ROWS(ACT_ROWS),
    .TRAIL_ROWS(TRAIL_ROWS)
  ) dut_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .intLen(intLen),
    .vClk1(vClk1), .vClk2(vClk2), .xferGate(xferGate), .hClk1(hClk1),
    .hClk2(hClk2), .sumGate(sumGate), .rstGate(rstGate),
    .shutterOpen(shutterOpen), .pixValid(pixValid), .lineStart(lineStart),
    .frameEnd(frameEnd)
  );

  typedef struct { int at; bit ls; bit fe; } expItem_t;
  expItem_t expQ[$];

  int checks = 0, errors = 0;
  int v1Pulses = 0, v2Pulses = 0, h2Pulses = 0, rgPulses = 0;
  int vRunErr = 0, gateErr = 0, ovlErr = 0, hErr = 0, rgErr = 0, shutErr = 0, markErr = 0;
  bit done = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int allPins();
    return int'({vClk1, vClk2, xferGate, hClk1, hClk2, sumGate, rstGate,
                 shutterOpen, pixValid, lineStart, frameEnd});
  endfunction

  // monitor: run lengths, relations and scoreboard pops
  int v1Run = 0, v2Run = 0, h2Run = 0, rgRun = 0, tgFallAt = 0;
  bit tgPend = 0, prevTg = 0, prevH2 = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (xferGate !== vClk2 || sumGate !== hClk2) gateErr++;
      if (hClk1 && hClk2) hErr++;
      if (shutterOpen && (vClk1 || vClk2 || hClk1)) shutErr++;
      if (!pixValid && (lineStart || frameEnd)) markErr++;
      if (vClk1) v1Run++;
      else if (v1Run != 0) begin if (v1Run != VPULSE) vRunErr++; v1Pulses++; v1Run = 0; end
      if (vClk2) v2Run++;
      else if (v2Run != 0) begin if (v2Run != VPULSE) vRunErr++; v2Pulses++; v2Run = 0; end
      if (hClk2) h2Run++;
      else if (h2Run != 0) begin if (h2Run != HHALF) hErr++; h2Pulses++; h2Run = 0; end
      if (rstGate) begin rgRun++; if (!hClk2) rgErr++; end
      else if (rgRun != 0) begin if (rgRun != RSTW) rgErr++; rgPulses++; rgRun = 0; end
      if (prevTg && !xferGate) begin
        tgFallAt = cyc; tgPend = 1;
        if (!hClk1) ovlErr++;
      end
      if (!prevH2 && hClk2 && tgPend) begin
        if (cyc - tgFallAt != OVLP_CYC) ovlErr++;
        tgPend = 0;
      end
      prevTg = xferGate;
      prevH2 = hClk2;
      if (pixValid) begin
        if (expQ.size() == 0) check("R9", "unexpected pixValid at cycle", cyc, -1);
        else begin
          expItem_t it;
          it = expQ.pop_front();
          check("R9", "pixValid cycle", cyc, it.at);
          check("R10", "lineStart flag", int'(lineStart), int'(it.ls));
          check("R10", "frameEnd flag", int'(frameEnd), int'(it.fe));
        end
      end
    end
  end

  task automatic waitCyc(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic pulseStart();
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  // driver: start a frame, push its schedule, check its timing
  task automatic runFrame(input int len, input int extraOff);
    int s, k, L, F;
    v1Pulses = 0; v2Pulses = 0; h2Pulses = 0; rgPulses = 0;
    @(negedge clk);
    s = cyc;
    intLen = INT_W'(len);
    pulseStart();
    k = s + 1;
    L = (len == 0) ? 1 : len;
    for (int r = LEAD_ROWS; r < LEAD_ROWS + ACT_ROWS; r++) begin
      for (int j = 0; j < SIG_PIX; j++) begin
        expItem_t it;
        it.at = k + L + r * ROWCYC + 2 * VPULSE + OVLP_CYC + (DUM_A + DUM_B + j) * PIX_CYC + PIX_CYC;
        it.ls = (j == 0);
        it.fe = (j == SIG_PIX - 1) && (r == LEAD_ROWS + ACT_ROWS - 1);
        expQ.push_back(it);
      end
    end
    F = k + L + TOTAL_ROWS * ROWCYC;
    waitCyc(k);     check("R3", "shutter before open", int'(shutterOpen), 0);
    waitCyc(k + 1); check("R3", "shutter opens", int'(shutterOpen), 1);
    if (extraOff < L) begin
      waitCyc(k + extraOff); pulseStart();  // R2 start during integration
    end
    waitCyc(k + L);     check("R3", "shutter last open cycle", int'(shutterOpen), 1);
    waitCyc(k + L + 1); check("R3", "shutter closed for readout", int'(shutterOpen), 0);
    check("R4", "vClk1 rises after integration", int'(vClk1), 1);
    if (extraOff >= L) begin
      waitCyc(k + extraOff); pulseStart();  // R2 start during readout
    end
    waitCyc(F);     check("R7", "last line ends in hClk1 half", int'(hClk1), 1);
    waitCyc(F + 1); check("R11", "all outputs low after frame", allPins(), 0);
    check("R9", "scoreboard drained", expQ.size(), 0);
    check("R4", "vClk1 pulses per frame", v1Pulses, TOTAL_ROWS);
    check("R4", "vClk2 pulses per frame", v2Pulses, TOTAL_ROWS);
    check("R7", "hClk2 pulses per frame", h2Pulses, TOTAL_ROWS * LINE_PIX);
    check("R8", "rstGate pulses per frame", rgPulses, TOTAL_ROWS * LINE_PIX);
    waitCyc(F + 40);
    check("R2", "no extra frame after ignored start", v1Pulses, TOTAL_ROWS);
    check("R11", "still idle", allPins(), 0);
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R11 watchdog expired actual=%0d expected=%0d", cyc, 20000);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "outputs during reset", allPins(), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "outputs after reset", allPins(), 0);
    runFrame(20, 100);   // extra start in readout
    runFrame(0, 200);    // minimum integration, extra start in readout
    runFrame(200, 50);   // extra start in integration
    check("R5", "gate copies mismatches", gateErr, 0);
    check("R4", "vertical pulse width errors", vRunErr, 0);
    check("R6", "overlap errors", ovlErr, 0);
    check("R7", "horizontal phase errors", hErr, 0);
    check("R8", "reset gate errors", rgErr, 0);
    check("R3", "shutter during readout", shutErr, 0);
    check("R10", "marker without pixValid", markErr, 0);
    done = 1;
    finishRun();
  end

endmodule